// File: doc/BRIEF.md
# Page Write Load Controller

This block is the write-side control of a byte-wide nonvolatile memory that programs a page of 64 bytes at once. It runs on one clock. It watches active-low chip-enable, output-enable and write-enable strobes, which are already synchronous, together with a 13-bit address and an 8-bit data bus. Each qualified write strobe loads one byte into a page register and marks the slot it filled. The first accepted byte fixes the page. Later bytes may land in any slot of that page, in any order, and a slot may be overwritten.

When no new strobe has come within the byte-load window, loading closes and a self-timed programming period starts. At the end of that period only the marked slots are copied into a behavioural memory array. The other bytes of the page keep their contents. The `busy` output is high from the first accepted byte until that copy is done. A strobe that names a different page during a load is dropped and raises a sticky error flag.

The strobes are plain control pins, so there is no back-pressure. The host reads `busy` and holds off new writes while it is high. Strobes that arrive during programming are lost. The behavioural array holds `ARRAY_PAGES` pages, and the low bits of the page number pick which page is used. A combinational read port returns array contents. All durations are parameters counted in clock cycles.

Top module: `page_write_loader`

## Requirements
- R1: A write strobe is active only in cycles where `ce_n`=0, `we_n`=0 and `oe_n`=1. Holding `oe_n` low, or `ce_n` high, for the whole pulse loads nothing and leaves `busy` at 0.
- R2: A strobe loads a byte only if it stays active for at least `FILT_CYC` (default 3) consecutive cycles. A shorter pulse loads nothing.
- R3: The byte address is taken from `addr` in the first active cycle of the strobe. The data is taken from `din` in the last active cycle of the strobe.
- R4: The byte is accepted in the cycle after the strobe ends. In IDLE, an accepted byte raises `busy` on the next cycle and latches `addr[12:6]` as the page of the load.
- R5: Loading stays open while each new strobe begins no later than `BLC_CYC` cycles after the accepting cycle of the previous byte. Once `BLC_CYC` cycles pass with no strobe activity after the last accepting cycle, loading closes and programming starts.
- R6: During a load, a strobe whose `addr[12:6]` differs from the latched page writes nothing and sets `page_err`. `page_err` stays 1 until reset.
- R7: Slots may be loaded in any order. When one slot is loaded twice in the same load, the later byte is the one programmed.
- R8: Programming lasts `WC_CYC` cycles. For a load that ends by timeout, `busy` is first seen low `BLC_CYC`+`WC_CYC`+1 clock edges after the strobe ends, counting the accepting edge.
- R9: At commit, only the slots loaded in this load are written. Every other byte of that page keeps its previous value.
- R10: Strobes that end while programming is running are ignored.
- R11: After reset, `busy`=0, `page_err`=0, and every array byte reads 8'hFF.
- R12: `rd_data` shows, in the same cycle, the array byte at `rd_addr`. `rd_addr` is {page[3:0], slot[5:0]}, where page is `addr[12:6]` folded to its low 4 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low (low blocks writes) |
| we_n | input | 1 | Write enable, active low |
| addr | input | 13 | Byte address: [12:6] page, [5:0] slot |
| din | input | 8 | Write data |
| rd_addr | input | 10 | Array read address {folded page, slot} |
| rd_data | output | 8 | Array byte at rd_addr |
| busy | output | 1 | High from first accepted byte until commit |
| page_err | output | 1 | Sticky: a strobe named a foreign page during a load |

## Verification
Two functions can fall on the same clock edge: the byte-load timeout expiring and a new strobe starting. One directed case starts the next strobe exactly `BLC_CYC` cycles after the accepting cycle, so that strobe must keep the load open and be programmed. Starting one cycle later must leave the byte out of the array, because the load has already moved to programming. Both outcomes are judged by reading the page back after `busy` falls, and by counting the edges until `busy` falls.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pwl_state_e;
endpackage

// File: rtl/pwl_strobe.sv
module pwl_strobe #(
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 8,
  parameter int FILT_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              act,
  output logic              done,
  output logic [ADDR_W-1:0] addr_cap,
  output logic [DATA_W-1:0] data_cap
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic          act_q;
  logic [CW-1:0] cnt_q;

  assign act  = ~ce_n & ~we_n & oe_n;
  assign done = act_q & ~act & (cnt_q >= CW'(FILT_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      cnt_q    <= '0;
      addr_cap <= '0;
      data_cap <= '0;
    end else begin
      act_q <= act;
      if (act) begin
        if (cnt_q != CW'(FILT_CYC)) cnt_q <= cnt_q + 1'b1;
        data_cap <= din;
        if (!act_q) addr_cap <= addr;
      end else begin
        cnt_q <= '0;
      end
    end
  end

  AST_DONE_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(act) && !act); // R2
endmodule

// File: rtl/pwl_pagebuf.sv
module pwl_pagebuf #(
  parameter int SLOT_W = 6,
  parameter int DATA_W = 8,
  localparam int PAGE_BYTES = 1 << SLOT_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [SLOT_W-1:0]            wr_slot,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         clr,
  output logic [PAGE_BYTES-1:0]        mask,
  output logic [PAGE_BYTES*DATA_W-1:0] data_flat
);
  logic [DATA_W-1:0] slot_q [PAGE_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
    end else if (clr) begin
      mask <= '0;
    end else if (wr_en) begin
      mask[wr_slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) slot_q[wr_slot] <= wr_data;
  end

  for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_flat
    assign data_flat[s*DATA_W +: DATA_W] = slot_q[s];
  end

  AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (mask == '0)); // R9
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !clr) |=> $stable(mask)); // R9
endmodule

// File: rtl/pwl_array.sv
module pwl_array #(
  parameter int DATA_W      = 8,
  parameter int SLOT_W      = 6,
  parameter int ARRAY_PAGES = 16,
  localparam int PAGE_BYTES = 1 << SLOT_W,
  localparam int APG_W      = $clog2(ARRAY_PAGES),
  localparam int RD_W       = APG_W + SLOT_W,
  localparam int DEPTH      = ARRAY_PAGES * PAGE_BYTES
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         commit,
  input  logic [APG_W-1:0]             commit_page,
  input  logic [PAGE_BYTES-1:0]        mask,
  input  logic [PAGE_BYTES*DATA_W-1:0] data_flat,
  input  logic [RD_W-1:0]              rd_addr,
  output logic [DATA_W-1:0]            rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (commit) begin
      for (int s = 0; s < PAGE_BYTES; s++) begin
        if (mask[s]) mem[{commit_page, SLOT_W'(s)}] <= data_flat[s*DATA_W +: DATA_W];
      end
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/page_write_loader.sv
module page_write_loader
  import pwl_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int SLOT_W      = 6,
  parameter int ARRAY_PAGES = 16,
  parameter int FILT_CYC    = 3,
  parameter int BLC_CYC     = 20,
  parameter int WC_CYC      = 40,
  localparam int PAGE_W     = ADDR_W - SLOT_W,
  localparam int PAGE_BYTES = 1 << SLOT_W,
  localparam int APG_W      = $clog2(ARRAY_PAGES),
  localparam int RD_W       = APG_W + SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic [RD_W-1:0]   rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              page_err
);
  localparam int BTW = $clog2(BLC_CYC + 1);
  localparam int WTW = $clog2(WC_CYC + 1);

  logic                         act, done;
  logic [ADDR_W-1:0]            addr_cap;
  logic [DATA_W-1:0]            data_cap;
  logic [PAGE_BYTES-1:0]        mask;
  logic [PAGE_BYTES*DATA_W-1:0] data_flat;

  pwl_state_e        state_q;
  logic [PAGE_W-1:0] page_q;
  logic [BTW-1:0]    tmr_q;
  logic [WTW-1:0]    wc_q;
  logic              err_q;
  logic              page_hit, accept, mismatch, commit, expire;

  pwl_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FILT_CYC(FILT_CYC)) u_strobe (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .act(act), .done(done),
    .addr_cap(addr_cap), .data_cap(data_cap)
  );

  assign page_hit = (addr_cap[ADDR_W-1:SLOT_W] == page_q);
  assign accept   = done && ((state_q == ST_IDLE) || (state_q == ST_LOAD && page_hit));
  assign mismatch = done && (state_q == ST_LOAD) && !page_hit;
  assign expire   = (state_q == ST_LOAD) && !act && !done && (tmr_q == BTW'(BLC_CYC - 1));
  assign commit   = (state_q == ST_PROG) && (wc_q == WTW'(WC_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      tmr_q   <= '0;
      wc_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      if (mismatch) err_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            page_q  <= addr_cap[ADDR_W-1:SLOT_W];
            tmr_q   <= '0;
            state_q <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (act || done) begin
            tmr_q <= '0;
          end else if (expire) begin
            wc_q    <= '0;
            state_q <= ST_PROG;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_PROG: begin
          if (commit) state_q <= ST_IDLE;
          else        wc_q    <= wc_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  pwl_pagebuf #(.SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_pagebuf (
    .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_slot(addr_cap[SLOT_W-1:0]),
    .wr_data(data_cap), .clr(commit), .mask(mask), .data_flat(data_flat)
  );

  pwl_array #(.DATA_W(DATA_W), .SLOT_W(SLOT_W), .ARRAY_PAGES(ARRAY_PAGES)) u_array (
    .clk(clk), .rst_n(rst_n), .commit(commit), .commit_page(page_q[APG_W-1:0]),
    .mask(mask), .data_flat(data_flat), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign busy     = (state_q != ST_IDLE);
  assign page_err = err_q;

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |=> page_err); // R6
  AST_PROG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PROG) |-> (wc_q < WTW'(WC_CYC))); // R8
  AST_PROG_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PROG && !commit) |=> (state_q == ST_PROG) && $stable(mask)); // R10
  AST_MISMATCH_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> $stable(mask) || (mask == '0)); // R6
endmodule

// File: tb/sim_page_write_loader.sv
module sim_page_write_loader;
  localparam int FILT = 3;
  localparam int BLC  = 20;
  localparam int WC   = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [12:0] addr = '0;
  logic [7:0]  din = '0;
  logic [9:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        busy, page_err;

  int nchk = 0, nerr = 0;
  bit finished = 0;
  logic [7:0] model [1024];

  always #2 clk = ~clk;

  page_write_loader #(.FILT_CYC(FILT), .BLC_CYC(BLC), .WC_CYC(WC)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .page_err(page_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] fold(input logic [12:0] a);
    return a[9:0];
  endfunction

  task automatic strobe(input logic [12:0] a, input logic [7:0] d, input int len, input logic oe);
    @(negedge clk);
    addr = a; din = d; oe_n = oe; ce_n = 1'b0; we_n = 1'b0;
    repeat (len) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic measure(output int n, output bit first_busy);
    n = 0; first_busy = 0;
    while (1) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (n == 1) first_busy = busy;
      if (!busy || n > 5000) break;
    end
  endtask

  task automatic rd(input logic [9:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic chk_byte(input logic [12:0] a, input string tag);
    logic [7:0] d;
    rd(fold(a), d);
    chk(d == model[fold(a)], tag, d, model[fold(a)]);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int n; bit fb; logic [7:0] d;
    void'($urandom(32'd2718));
    for (int i = 0; i < 1024; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(busy == 0, "R11 busy after reset", busy, 0);
    chk(page_err == 0, "R11 page_err after reset", page_err, 0);
    for (int i = 0; i < 1024; i += 97) begin
      rd(10'(i), d); chk(d == 8'hFF, "R11 erased array", d, 8'hFF);
    end

    // R1 blocked strobes: oe low, then ce high
    strobe(13'h0010, 8'h99, 4, 1'b0);
    repeat (3) @(negedge clk);
    chk(busy == 0, "R1 oe_n low blocks write", busy, 0);
    @(negedge clk); addr = 13'h0011; ce_n = 1'b1; we_n = 1'b0; oe_n = 1'b1;
    repeat (4) @(negedge clk); we_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 0, "R1 ce_n high blocks write", busy, 0);

    // R2 short pulse filtered
    strobe(13'h0040, 8'hC3, FILT - 1, 1'b1);
    repeat (3) @(negedge clk);
    chk(busy == 0, "R2 short pulse ignored", busy, 0);
    // R2/R4/R8 minimum pulse, timing of a single-byte load
    strobe(13'h0041, 8'h5A, FILT, 1'b1);
    measure(n, fb);
    chk(fb == 1, "R4 busy after first byte", fb, 1);
    chk(n == BLC + WC + 1, "R8 load plus program length", n, BLC + WC + 1);
    model[fold(13'h0041)] = 8'h5A;
    chk_byte(13'h0041, "R2 full pulse written");
    chk_byte(13'h0040, "R9 unloaded slot kept");

    // R3 address from first cycle, data from last cycle
    @(negedge clk);
    addr = 13'h0080; din = 8'h11; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); addr = 13'h00C5; din = 8'h22;
    @(negedge clk); din = 8'h33;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
    measure(n, fb);
    model[fold(13'h0080)] = 8'h33;
    chk_byte(13'h0080, "R3 first-cycle address, last-cycle data");
    chk_byte(13'h00C5, "R3 late address not used");

    // R5 boundary gap, R7 order and overwrite, R12 folding
    strobe(13'h1103, 8'hA1, FILT, 1'b1);
    repeat (BLC - 1) @(negedge clk);
    strobe(13'h1102, 8'hB2, FILT, 1'b1);
    strobe(13'h1105, 8'h11, FILT, 1'b1);
    strobe(13'h1105, 8'h22, FILT, 1'b1);
    measure(n, fb);
    chk(n == BLC + WC + 1, "R5 load held open by boundary strobe", n, BLC + WC + 1);
    model[fold(13'h1103)] = 8'hA1; model[fold(13'h1102)] = 8'hB2; model[fold(13'h1105)] = 8'h22;
    chk_byte(13'h1102, "R5 boundary byte programmed");
    chk_byte(13'h1103, "R12 folded page read");
    chk_byte(13'h1105, "R7 last overwrite wins");
    chk_byte(13'h1104, "R9 untouched slot");

    // R5 expiry one cycle later: byte lands in programming and is lost
    strobe(13'h0200, 8'h77, FILT, 1'b1);
    repeat (BLC) @(negedge clk);
    strobe(13'h0201, 8'h88, FILT, 1'b1);
    measure(n, fb);
    model[fold(13'h0200)] = 8'h77;
    chk_byte(13'h0200, "R5 first byte programmed");
    chk_byte(13'h0201, "R5 late byte not loaded");

    // R10 strobe deep in programming
    strobe(13'h0300, 8'h01, FILT, 1'b1);
    repeat (BLC + 5) @(negedge clk);
    chk(busy == 1, "R10 programming running", busy, 1);
    strobe(13'h0302, 8'h02, FILT, 1'b1);
    measure(n, fb);
    model[fold(13'h0300)] = 8'h01;
    chk_byte(13'h0302, "R10 strobe during programming ignored");
    chk_byte(13'h0300, "R10 loaded byte programmed");

    // R6 foreign page
    chk(page_err == 0, "R6 no error yet", page_err, 0);
    strobe(13'h0380, 8'h12, FILT, 1'b1);
    strobe(13'h03C1, 8'h34, FILT, 1'b1);
    @(negedge clk);
    chk(page_err == 1, "R6 error raised", page_err, 1);
    strobe(13'h0381, 8'h56, FILT, 1'b1);
    measure(n, fb);
    model[fold(13'h0380)] = 8'h12; model[fold(13'h0381)] = 8'h56;
    chk_byte(13'h0380, "R6 own page byte");
    chk_byte(13'h0381, "R6 load continues");
    chk_byte(13'h03C1, "R6 foreign byte dropped");

    // random loads
    for (int it = 0; it < 12; it++) begin
      logic [6:0] pg;
      logic [7:0] pd [64];
      bit pv [64];
      int nb;
      pg = 7'($urandom % 128);
      nb = 1 + int'($urandom % 6);
      for (int s = 0; s < 64; s++) pv[s] = 0;
      for (int b = 0; b < nb; b++) begin
        logic [5:0] sl; logic [7:0] dv;
        sl = (it % 2 == 1) ? 6'($urandom % 4) : 6'($urandom % 64);
        dv = 8'($urandom);
        pd[sl] = dv; pv[sl] = 1;
        if (b > 0) repeat (int'($urandom % BLC)) @(negedge clk);
        strobe({pg, sl}, dv, FILT + int'($urandom % 3), 1'b1);
      end
      measure(n, fb);
      chk(n == BLC + WC + 1, "R8 random load timing", n, BLC + WC + 1);
      for (int s = 0; s < 64; s++) if (pv[s]) model[{pg[3:0], 6'(s)}] = pd[s];
      for (int s = 0; s < 64; s++) chk_byte({pg, 6'(s)}, "R9 random page content");
    end
    chk(page_err == 1, "R6 error sticky", page_err, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule